// File: doc/BRIEF.md
# Prioritized Interrupt Request Arbiter

This block watches eight interrupt request lines and raises a single interrupt line towards a processor. Each rising edge on a request line is latched as a pending request. Pending requests pass through an eight-bit enable mask, and a fixed-priority resolver picks one winner, where line 0 ranks highest. The block raises the interrupt line only when the winner outranks every interrupt that is already in service. Lower-ranked requests therefore wait until service ends, and higher-ranked ones may nest on top.

When the processor acknowledges, the block moves the winner from pending to in service. For one cycle it then presents an eight-bit vector formed from a programmable base and the winner's line number. An end-of-interrupt pulse retires the highest-ranked in-service entry. The mask, the vector base and the end-of-interrupt pulse arrive as plain inputs from a separate configuration block. The mask is registered inside the arbiter and resets to all ones.

Top module: `irq_prio_arbiter`

## Requirements
- R1: A rising edge on `irqIn[n]` sets pending request n. `intReq` can rise at the second clock edge after the edge is first sampled. An input held high makes no further request once that request has been served.
- R2: A `maskIn` bit of 1 blocks its line and a 0 enables it, with effect from the next clock edge. A blocked request stays pending and is served once its mask bit is cleared.
- R3: When several enabled requests are pending, the lowest line number wins.
- R4: The vector carries `vecBase[7:3]` in bits 7:3 and the winning line number in bits 2:0. For example, base 08h and line 1 give 09h.
- R5: `intReq` is raised only when the winner ranks higher than every in-service entry. A lower-ranked request waits until the entries above it are retired.
- R6: An acknowledge taken while `intReq` is high has these effects. It clears the winner's pending bit and sets its in-service bit. It drives `vecValid` high for exactly one cycle, with the vector on `vecOut`. It forces `intReq` low in the cycle that follows.
- R7: An `eoiPulse` clears only the highest-ranked set in-service bit.
- R8: An `eoiPulse` while nothing is in service changes nothing.
- R9: `ackIn` while `intReq` is low is ignored: no vector is produced and no state changes.
- R10: Reset clears all pending and in-service bits and holds `intReq`, `vecValid` and `vecOut` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqIn | input | 8 | Request lines, line 0 highest priority |
| maskIn | input | 8 | Enable mask, 1 blocks a line |
| vecBase | input | 8 | Vector base, bits 7:3 used |
| eoiPulse | input | 1 | End-of-interrupt strobe, one cycle |
| ackIn | input | 1 | Processor acknowledge strobe |
| intReq | output | 1 | Interrupt request to the processor |
| vecOut | output | 8 | Vector, valid with vecValid |
| vecValid | output | 1 | One-cycle vector strobe |

## Verification
The hardest situation to reach is a two-deep nest with a third request held behind it. That state needs a lower-ranked request to be served first and a higher-ranked one to preempt it. A blocked request must also remain pending while the two in-service entries are retired one end-of-interrupt at a time. The stimulus table builds this step by step: it releases a request that was latched while masked, adds a lower-ranked edge, and then injects line 0. Each retirement is followed by a sample of `intReq` to confirm that only the right entry was cleared. Directed tests cover the remaining cases: a line held high, a changed vector base, a stray acknowledge, and a reset taken mid-nest.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef struct packed {
    logic ackTake;
    logic eoiDo;
  } arbStrobe_t;
endpackage

// File: rtl/irq_arb_datapath.sv
module irq_arb_datapath
  import irq_arb_pkg::*;
#(
  parameter int IRQ_COUNT = 8,
  parameter int VEC_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [IRQ_COUNT-1:0] irqIn,
  input  logic [IRQ_COUNT-1:0] maskIn,
  input  logic [VEC_W-1:0]     vecBase,
  input  arbStrobe_t           strb,
  output logic                 fire,
  output logic [VEC_W-1:0]     vecOut,
  output logic                 vecValid
);
  localparam int IDX_W = $clog2(IRQ_COUNT);

  logic [IRQ_COUNT-1:0] prevIrq, reqReg, maskReg, isrReg;
  logic [IRQ_COUNT-1:0] edges, cand, ackBit, eoiBit;
  logic [IDX_W-1:0]     winIdx, isrTop;
  logic                 candAny, isrAny;

  function automatic logic [IDX_W-1:0] firstIdx(input logic [IRQ_COUNT-1:0] v);
    firstIdx = '0;
    for (int i = IRQ_COUNT - 1; i >= 0; i--)
      if (v[i]) firstIdx = IDX_W'(i);
  endfunction

  // per-line rising-edge detect
  for (genvar g = 0; g < IRQ_COUNT; g++) begin : g_edge
    assign edges[g] = irqIn[g] & ~prevIrq[g];
  end

  always_comb begin
    cand    = reqReg & ~maskReg;
    candAny = |cand;
    winIdx  = firstIdx(cand);
    isrAny  = |isrReg;
    isrTop  = firstIdx(isrReg);
    fire    = candAny && (!isrAny || (winIdx < isrTop));
    ackBit  = strb.ackTake ? (IRQ_COUNT'(1) << winIdx) : '0;
    eoiBit  = (strb.eoiDo && isrAny) ? (IRQ_COUNT'(1) << isrTop) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevIrq  <= '0;
      reqReg   <= '0;
      maskReg  <= '1;
      isrReg   <= '0;
      vecOut   <= '0;
      vecValid <= 1'b0;
    end else begin
      prevIrq  <= irqIn;
      maskReg  <= maskIn;
      reqReg   <= (reqReg & ~ackBit) | edges;
      isrReg   <= (isrReg & ~eoiBit) | ackBit;
      vecValid <= strb.ackTake;
      vecOut   <= strb.ackTake ? {vecBase[VEC_W-1:IDX_W], winIdx} : '0;
    end
  end

  // R1
  new_req_from_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((reqReg & ~$past(reqReg)) & ~$past(edges)) == '0);
  // R2
  ack_unmasked_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackTake |-> !maskReg[winIdx]);
  // R4
  vec_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> vecOut[VEC_W-1:IDX_W] == $past(vecBase[VEC_W-1:IDX_W]));
  // R6
  ack_sets_isr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ackTake && !strb.eoiDo) |=> $countones(isrReg) == $past($countones(isrReg)) + 1);
  // R7
  eoi_drops_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.eoiDo && isrAny && !strb.ackTake) |=> $countones(isrReg) == $past($countones(isrReg)) - 1);
  // R8
  eoi_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.eoiDo && !isrAny && !strb.ackTake) |=> isrReg == '0);
endmodule

// File: rtl/irq_arb_control.sv
module irq_arb_control
  import irq_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ackIn,
  input  logic       eoiPulse,
  input  logic       fire,
  output arbStrobe_t strb,
  output logic       intReq
);
  always_comb begin
    strb.ackTake = ackIn && intReq;
    strb.eoiDo   = eoiPulse;
  end

  always_ff @(posedge clk) begin
    if (!rstN) intReq <= 1'b0;
    else       intReq <= fire && !strb.ackTake;
  end

  // R6
  int_drops_on_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.ackTake |=> !intReq);
  // R5
  int_follows_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> $past(fire));
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter int IRQ_COUNT = 8,
  parameter int VEC_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [IRQ_COUNT-1:0] irqIn,
  input  logic [IRQ_COUNT-1:0] maskIn,
  input  logic [VEC_W-1:0]     vecBase,
  input  logic                 eoiPulse,
  input  logic                 ackIn,
  output logic                 intReq,
  output logic [VEC_W-1:0]     vecOut,
  output logic                 vecValid
);
  arbStrobe_t strb;
  logic       fire;

  irq_arb_control u_ctrl (
    .clk(clk), .rstN(rstN), .ackIn(ackIn), .eoiPulse(eoiPulse),
    .fire(fire), .strb(strb), .intReq(intReq)
  );

  irq_arb_datapath #(.IRQ_COUNT(IRQ_COUNT), .VEC_W(VEC_W)) u_dp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .maskIn(maskIn), .vecBase(vecBase),
    .strb(strb), .fire(fire), .vecOut(vecOut), .vecValid(vecValid)
  );

  // R6
  vec_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |=> !vecValid);
  // R10
  idle_after_reset_chk: assert property (@(posedge clk)
    !rstN |=> (!intReq && !vecValid));
endmodule

// File: tb/test_irq_prio_arbiter.sv
`timescale 1ns/1ps
module test_irq_prio_arbiter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] irqIn = '0, maskIn = '0, vecBase = 8'h08;
  logic eoiPulse = 1'b0, ackIn = 1'b0;
  logic intReq, vecValid;
  logic [7:0] vecOut;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_prio_arbiter i_irq_prio_arbiter (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .maskIn(maskIn), .vecBase(vecBase),
    .eoiPulse(eoiPulse), .ackIn(ackIn), .intReq(intReq), .vecOut(vecOut),
    .vecValid(vecValid)
  );

  // {mask, pulse, eoi, ack, expInt, expIdx}
  localparam logic [21:0] STEPS [12] = '{
    {8'hFF, 8'h02, 1'b0, 1'b0, 1'b0, 3'd0},  // R2 latched while blocked
    {8'hFD, 8'h00, 1'b0, 1'b1, 1'b1, 3'd1},  // R2 released
    {8'h00, 8'h08, 1'b0, 1'b0, 1'b0, 3'd0},  // R5 lower held off
    {8'h00, 8'h01, 1'b0, 1'b1, 1'b1, 3'd0},  // R5 preempt
    {8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 3'd0},  // R7 clears line 0 only
    {8'h00, 8'h00, 1'b1, 1'b1, 1'b1, 3'd3},  // R7 then line 3 served
    {8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 3'd0},
    {8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 3'd0},  // R8 eoi while empty
    {8'h00, 8'h60, 1'b0, 1'b1, 1'b1, 3'd5},  // R3 tie
    {8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0},  // R5 line 6 behind 5
    {8'h00, 8'h00, 1'b1, 1'b1, 1'b1, 3'd6},
    {8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 3'd0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ackAndCheck(input string req, input logic [7:0] expVec);
    ackIn = 1'b1;
    @(negedge clk) ackIn = 1'b0;
    chk({req, " R6 vecValid"}, {7'd0, vecValid}, 8'd1);
    chk({req, " R4 vecOut"}, vecOut, expVec);
    chk({req, " R6 intReq low"}, {7'd0, intReq}, 8'd0);
    @(negedge clk);
    chk({req, " R6 vecValid single"}, {7'd0, vecValid}, 8'd0);
  endtask

  task automatic stim(input logic [7:0] pulse, input logic eoi);
    @(negedge clk) irqIn = pulse; eoiPulse = eoi;
    @(negedge clk) irqIn = '0; eoiPulse = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 intReq", {7'd0, intReq}, 8'd0);
    chk("R10 vecValid", {7'd0, vecValid}, 8'd0);
    chk("R10 vecOut", vecOut, 8'd0);
    rstN = 1'b1;
    maskIn = 8'hFF;
    @(negedge clk);

    for (int i = 0; i < 12; i++) begin
      logic [21:0] s;
      s = STEPS[i];
      maskIn = s[21:14];
      stim(s[13:6], s[5]);
      chk($sformatf("R5 step %0d intReq", i), {7'd0, intReq}, {7'd0, s[3]});
      if (s[4]) ackAndCheck($sformatf("R3 step %0d", i), {vecBase[7:3], s[2:0]});
    end

    // R9 stray acknowledge
    ackIn = 1'b1;
    @(negedge clk) ackIn = 1'b0;
    chk("R9 no vector", {7'd0, vecValid}, 8'd0);
    @(negedge clk);
    chk("R9 no intReq", {7'd0, intReq}, 8'd0);

    // R1 held level gives one request only
    @(negedge clk) irqIn = 8'h10;
    repeat (2) @(negedge clk);
    chk("R1 edge raises intReq", {7'd0, intReq}, 8'd1);
    ackAndCheck("R1", 8'h0C);
    stim(8'h10, 1'b1);
    repeat (2) @(negedge clk);
    chk("R1 level no new request", {7'd0, intReq}, 8'd0);
    irqIn = '0;

    // R4 other base
    vecBase = 8'hA5;
    stim(8'h04, 1'b0);
    chk("R4 intReq", {7'd0, intReq}, 8'd1);
    ackAndCheck("R4 base A5", 8'hA2);
    stim(8'h00, 1'b1);

    // R10 reset mid-nest
    stim(8'h02, 1'b0);
    ackAndCheck("R10 setup", 8'hA1);
    stim(8'h10, 1'b0);
    chk("R10 blocked before reset", {7'd0, intReq}, 8'd0);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 pending cleared", {7'd0, intReq}, 8'd0);
    stim(8'h40, 1'b0);
    chk("R10 in-service cleared", {7'd0, intReq}, 8'd1);
    ackAndCheck("R10", 8'hA6);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule